// File: doc/BRIEF.md
# Descriptor Fetch and Completion Write-Back Engine

This engine lets a host hand free receive buffers to three receive channels and collect their completion reports without touching the card one register at a time. The host builds a list of 64-bit entries in system memory and pulses a doorbell. The engine reads the list word by word over a simple memory read port and drops each buffer address into the request queue of the channel the entry names. It stops at the first entry whose valid flag is clear.

In the other direction, the channels report finished fragments as length/status records. The engine queues these records in arrival order. When enough of them are pending, or when a few have waited too long, it writes them as one burst into a ring in host memory. The ring's size is set by the host. The engine then publishes a new write index and can raise a one-cycle interrupt. The host consumes records and reports its progress through a read index. The engine never overwrites records the host has not yet consumed.

Top module: `desc_cpl_dma`

## Requirements
- R1: On a doorbell the engine reads 64-bit entries starting at `desc_base`, at consecutive 8-byte addresses. In each entry, bits [1:0] hold the channel, bit 2 is the valid flag, and bits [31:3] are the page address, whose low 3 bits are forced to zero. Each valid entry puts its page address into that channel's request queue, and a channel sees its entries in list order.
- R2: An entry with bit 2 clear ends the list. No further memory read is issued and no later entry is loaded.
- R3: A valid entry whose channel field is 3 is skipped. Parsing continues with the next entry.
- R4: When an entry targets a full request queue, parsing waits until that queue has space. No address is lost and no read is issued meanwhile.
- R5: A completion record is 64 bits: length in [19:0], status in [27:20], channel in [33:32], and all other bits zero. Records reach memory in the order they were accepted.
- R6: Write-back starts once the pending count is at or above `cpl_threshold` (a threshold of 0 disables this trigger). It writes min(pending, free ring slots) records to `ring_base` + 8 × index, with the index wrapping at `ring_size`, and flags the final beat with `mem_wr_last`.
- R7: With `cpl_timeout` non-zero, records pending below the threshold are flushed after about `cpl_timeout` cycles. They are not flushed before then.
- R8: `ring_wr_idx` changes only after the last beat of a block is acknowledged, and then moves past every record of that block.
- R9: The ring holds at most `ring_size`-1 unread records. While it is full, no write is issued, even if records are pending. Writing resumes when `ring_rd_idx` moves.
- R10: With `irq_en` set, `irq` pulses for one cycle right after the last beat of a block is acknowledged. With `irq_en` clear, no pulse occurs.
- R11: The read and write requests stay asserted, with stable address (and data and last flag), until they are acknowledged.
- R12: After reset, no memory request is asserted, all request queues are empty, `ring_wr_idx` is 0, `irq` is low and `cpl_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| doorbell | input | 1 | Starts a list fetch (ignored while one is running) |
| desc_base | input | 32 | Byte address of the entry list |
| req_valid | output | 3 | Request queue of each channel is non-empty |
| req_pop | input | 3 | Channel takes the head address |
| req_addr | output | 96 | Head page address of each channel, channel 0 in the low 32 bits |
| cpl_valid | input | 1 | Completion record offered |
| cpl_ready | output | 1 | Completion queue has room |
| cpl_chan | input | 2 | Channel of the offered record |
| cpl_len | input | 20 | Fragment byte length |
| cpl_status | input | 8 | Fragment status bits |
| cpl_threshold | input | 4 | Pending count that triggers write-back |
| cpl_timeout | input | 16 | Flush delay in cycles, 0 = off |
| ring_base | input | 32 | Byte address of the completion ring |
| ring_size | input | 5 | Ring length in records (2..16) |
| ring_rd_idx | input | 4 | Host read index |
| ring_wr_idx | output | 4 | Engine write index |
| irq_en | input | 1 | Enables the block-done pulse |
| irq | output | 1 | Block-done pulse |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data valid, completes the request |
| mem_rd_data | input | 64 | Read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 64 | Write data |
| mem_wr_last | output | 1 | Final beat of a block |
| mem_wr_ack | input | 1 | Write beat accepted |

## Verification
The hardest state to reach from the ports is a full ring that still has records pending and a trigger already satisfied, with the next block having to wrap past the ring's end. The stimulus first fills the ring with earlier blocks until the write index sits near the top while the read index stays put. It then offers more records than there are free slots, so one block is cut short. Next it lowers the threshold so the leftover records are eligible but blocked. Only then does it advance the read index and expect a two-record block that lands on the last slot and on slot zero. Stalling a request queue works the same way: the list sends more entries to one channel than its queue holds, and no addresses are popped until the read count has frozen.

// File: rtl/dma_eng_pkg.sv
// Shared field layout for list entries and completion records.
// Assumes 64-bit memory words and at most four channels (2-bit id).
package dma_eng_pkg;
    localparam int WORD_W  = 64;
    localparam int CH_W    = 2;
    localparam int LEN_W   = 20;
    localparam int STAT_W  = 8;
    localparam int VLD_BIT = 2;

    // Pack one completion record: len [19:0], status [27:20], chan [33:32].
    function automatic logic [WORD_W-1:0] make_record(
        input logic [CH_W-1:0]   ch,
        input logic [LEN_W-1:0]  len,
        input logic [STAT_W-1:0] st
    );
        return {30'd0, ch, 4'd0, st, len};
    endfunction
endpackage

// File: rtl/sync_fifo.sv
// Single-clock FIFO with head-of-queue output and occupancy count.
// Assumes DEPTH is a power of two; push when full and pop when empty are not made.
module sync_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [W-1:0]   din,
    input  logic           pop,
    output logic [W-1:0]   dout,
    output logic           full,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wp, rp;

    // Data storage, written on push.
    always_ff @(posedge clk) begin
        if (push) store[wp] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    assign dout = store[rp];
    assign full = (count == (AW+1)'(DEPTH));
endmodule

// File: rtl/desc_fetch.sv
// Walks a host entry list one 64-bit word at a time and pushes page
// addresses into per-channel queues. Assumes mem_rd_valid arrives only
// while mem_rd_req is high, and ends the request.
module desc_fetch #(
    parameter int NCH    = 3,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              doorbell,
    input  logic [ADDR_W-1:0] desc_base,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [63:0]       mem_rd_data,
    input  logic [NCH-1:0]    q_full,
    output logic [NCH-1:0]    q_push,
    output logic [ADDR_W-1:0] q_addr
);
    import dma_eng_pkg::*;

    typedef enum logic [1:0] {F_IDLE, F_READ, F_DISP} fstate_t;

    fstate_t           st;
    logic [63:0]       ent;
    logic [ADDR_W-1:0] rd_ptr;
    logic [CH_W-1:0]   ent_ch;
    logic              ent_vld, ch_ok, tgt_full;

    assign ent_ch  = ent[CH_W-1:0];
    assign ent_vld = ent[VLD_BIT];
    assign ch_ok   = int'(ent_ch) < NCH;

    // Full flag of the queue the current entry targets.
    always_comb begin
        tgt_full = 1'b0;
        for (int i = 0; i < NCH; i++)
            if (int'(ent_ch) == i) tgt_full = q_full[i];
    end

    // List walk: read, dispatch, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= F_IDLE;
            ent    <= '0;
            rd_ptr <= '0;
        end else begin
            case (st)
                F_IDLE: if (doorbell) begin
                    rd_ptr <= {desc_base[ADDR_W-1:3], 3'b000};
                    st     <= F_READ;
                end
                F_READ: if (mem_rd_valid) begin
                    ent <= mem_rd_data;
                    st  <= F_DISP;
                end
                F_DISP: begin
                    if (!ent_vld) begin
                        st <= F_IDLE;
                    end else if (!ch_ok || !tgt_full) begin
                        rd_ptr <= rd_ptr + ADDR_W'(8);
                        st     <= F_READ;
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // Queue push strobes for a valid, in-range entry with space.
    always_comb begin
        for (int i = 0; i < NCH; i++)
            q_push[i] = (st == F_DISP) && ent_vld && (int'(ent_ch) == i) && !q_full[i];
    end

    assign q_addr      = {ent[ADDR_W-1:3], 3'b000};
    assign mem_rd_req  = (st == F_READ);
    assign mem_rd_addr = rd_ptr;
endmodule

// File: rtl/cpl_writer.sv
// Drains queued completion records into a host ring in bursts. A burst
// starts on threshold or timeout and is sized to the free ring space.
// Assumes ring_size is between 2 and 2**IDX_W and ring_base is 8-byte aligned.
module cpl_writer #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 4,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  pend,
    input  logic [63:0]       head_rec,
    output logic              pop,
    input  logic [CNT_W-1:0]  threshold,
    input  logic [TMO_W-1:0]  timeout,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W:0]    ring_size,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              irq_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              irq,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [63:0]       mem_wr_data,
    output logic              mem_wr_last,
    input  logic              mem_wr_ack
);
    localparam int KW = (CNT_W > IDX_W + 1) ? CNT_W : IDX_W + 1;

    typedef enum logic {W_IDLE, W_BURST} wstate_t;

    wstate_t          st;
    logic [KW-1:0]    blk_len, beat;
    logic [IDX_W-1:0] ptr, ptr_nxt;
    logic [TMO_W-1:0] tcnt;
    logic [IDX_W:0]   wr_e, rd_e, occ, free;
    logic [KW-1:0]    pend_k, free_k, take;
    logic             trig, start, beat_done;

    // Ring occupancy and free space from the two indices.
    always_comb begin
        wr_e = {1'b0, wr_idx};
        rd_e = {1'b0, rd_idx};
        occ  = (wr_e >= rd_e) ? (wr_e - rd_e) : (wr_e + ring_size - rd_e);
        free = ring_size - 1'b1 - occ;
    end

    // Burst trigger and size selection.
    always_comb begin
        pend_k = KW'(pend);
        free_k = KW'(free);
        take   = (pend_k < free_k) ? pend_k : free_k;
        trig   = ((threshold != '0) && (pend >= threshold)) ||
                 ((timeout != '0) && (pend != '0) && (tcnt >= timeout));
        start  = (st == W_IDLE) && trig && (free != '0);
    end

    assign ptr_nxt   = (({1'b0, ptr} + 1'b1) == ring_size) ? '0 : ptr + 1'b1;
    assign beat_done = mem_wr_req && mem_wr_ack;

    // Burst sequencing, index commit and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= W_IDLE;
            blk_len <= '0;
            beat    <= '0;
            ptr     <= '0;
            wr_idx  <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (st)
                W_IDLE: if (start) begin
                    blk_len <= take;
                    beat    <= '0;
                    ptr     <= wr_idx;
                    st      <= W_BURST;
                end
                W_BURST: if (beat_done) begin
                    ptr  <= ptr_nxt;
                    beat <= beat + 1'b1;
                    if (mem_wr_last) begin
                        wr_idx <= ptr_nxt;
                        irq    <= irq_en;
                        st     <= W_IDLE;
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    // Age of the oldest idle-pending records, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || st != W_IDLE || pend == '0) tcnt <= '0;
        else if (tcnt != '1)                      tcnt <= tcnt + 1'b1;
    end

    assign mem_wr_req  = (st == W_BURST);
    assign mem_wr_addr = {ring_base[ADDR_W-1:3], 3'b000} + ADDR_W'({ptr, 3'b000});
    assign mem_wr_data = head_rec;
    assign mem_wr_last = (beat == blk_len - 1'b1);
    assign pop         = beat_done;
endmodule

// File: rtl/desc_cpl_dma.sv
// Top of the list-fetch and completion write-back engine: per-channel
// request queues, one arrival-ordered completion queue, the list walker
// and the ring writer. Assumes NCH <= 4 (2-bit channel field).
module desc_cpl_dma #(
    parameter int NCH       = 3,
    parameter int ADDR_W    = 32,
    parameter int REQ_DEPTH = 4,
    parameter int CPL_DEPTH = 8,
    parameter int IDX_W     = 4,
    parameter int TMO_W     = 16,
    localparam int CNT_W    = $clog2(CPL_DEPTH) + 1,
    localparam int RQ_CW    = $clog2(REQ_DEPTH) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  doorbell,
    input  logic [ADDR_W-1:0]     desc_base,
    output logic [NCH-1:0]        req_valid,
    input  logic [NCH-1:0]        req_pop,
    output logic [NCH*ADDR_W-1:0] req_addr,
    input  logic                  cpl_valid,
    output logic                  cpl_ready,
    input  logic [1:0]            cpl_chan,
    input  logic [19:0]           cpl_len,
    input  logic [7:0]            cpl_status,
    input  logic [CNT_W-1:0]      cpl_threshold,
    input  logic [TMO_W-1:0]      cpl_timeout,
    input  logic [ADDR_W-1:0]     ring_base,
    input  logic [IDX_W:0]        ring_size,
    input  logic [IDX_W-1:0]      ring_rd_idx,
    output logic [IDX_W-1:0]      ring_wr_idx,
    input  logic                  irq_en,
    output logic                  irq,
    output logic                  mem_rd_req,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_valid,
    input  logic [63:0]           mem_rd_data,
    output logic                  mem_wr_req,
    output logic [ADDR_W-1:0]     mem_wr_addr,
    output logic [63:0]           mem_wr_data,
    output logic                  mem_wr_last,
    input  logic                  mem_wr_ack
);
    logic [NCH-1:0]    q_full, q_push;
    logic [ADDR_W-1:0] q_addr;
    logic              cq_full, cq_pop;
    logic [CNT_W-1:0]  cq_cnt;
    logic [63:0]       cq_head;

    desc_fetch #(.NCH(NCH), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .desc_base(desc_base),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .q_full(q_full), .q_push(q_push), .q_addr(q_addr)
    );

    // One request queue per receive channel.
    for (genvar g = 0; g < NCH; g++) begin : g_reqq
        logic [RQ_CW-1:0] cnt;
        sync_fifo #(.W(ADDR_W), .DEPTH(REQ_DEPTH)) u_q (
            .clk(clk), .rst_n(rst_n),
            .push(q_push[g]), .din(q_addr),
            .pop(req_pop[g] && req_valid[g]),
            .dout(req_addr[g*ADDR_W +: ADDR_W]),
            .full(q_full[g]), .count(cnt)
        );
        assign req_valid[g] = (cnt != '0);
    end

    sync_fifo #(.W(64), .DEPTH(CPL_DEPTH)) u_cplq (
        .clk(clk), .rst_n(rst_n),
        .push(cpl_valid && cpl_ready),
        .din(dma_eng_pkg::make_record(cpl_chan, cpl_len, cpl_status)),
        .pop(cq_pop), .dout(cq_head), .full(cq_full), .count(cq_cnt)
    );
    assign cpl_ready = !cq_full;

    cpl_writer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .TMO_W(TMO_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .pend(cq_cnt), .head_rec(cq_head), .pop(cq_pop),
        .threshold(cpl_threshold), .timeout(cpl_timeout),
        .ring_base(ring_base), .ring_size(ring_size), .rd_idx(ring_rd_idx),
        .irq_en(irq_en), .wr_idx(ring_wr_idx), .irq(irq),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_last(mem_wr_last), .mem_wr_ack(mem_wr_ack)
    );
endmodule

// File: rtl/desc_cpl_dma_chk.sv
// Protocol and ordering checks on the engine's ports.
module desc_cpl_dma_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              mem_wr_req,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [63:0]       mem_wr_data,
    input logic              mem_wr_last,
    input logic              mem_wr_ack,
    input logic              irq,
    input logic              irq_en,
    input logic [IDX_W-1:0]  ring_wr_idx,
    input logic [IDX_W-1:0]  ring_rd_idx,
    input logic [IDX_W:0]    ring_size
);
    logic [IDX_W:0] c_occ;
    assign c_occ = (ring_wr_idx >= ring_rd_idx)
                 ? ({1'b0, ring_wr_idx} - {1'b0, ring_rd_idx})
                 : ({1'b0, ring_wr_idx} + ring_size - {1'b0, ring_rd_idx});

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr)); // R11
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr)
            && $stable(mem_wr_data) && $stable(mem_wr_last)); // R11
    AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_wr_req && mem_wr_ack && mem_wr_last && irq_en)); // R10
    AST_IDX_AT_BLOCK_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ring_wr_idx) |-> $past(mem_wr_req && mem_wr_ack && mem_wr_last)); // R8
    AST_NO_RING_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (c_occ < ring_size - 1'b1)); // R9
endmodule

bind desc_cpl_dma desc_cpl_dma_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/desc_cpl_dma_test.sv
`timescale 1ns/1ps
module desc_cpl_dma_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        doorbell = 1'b0;
    logic [31:0] desc_base = '0;
    logic [2:0]  req_valid, req_pop = '0;
    logic [95:0] req_addr;
    logic        cpl_valid = 1'b0, cpl_ready;
    logic [1:0]  cpl_chan = '0;
    logic [19:0] cpl_len = '0;
    logic [7:0]  cpl_status = '0;
    logic [3:0]  cpl_threshold = 4'd3;
    logic [15:0] cpl_timeout = '0;
    logic [31:0] ring_base = 32'h400;
    logic [4:0]  ring_size = 5'd8;
    logic [3:0]  ring_rd_idx = '0, ring_wr_idx;
    logic        irq_en = 1'b1, irq;
    logic        mem_rd_req, mem_rd_valid;
    logic [31:0] mem_rd_addr, mem_wr_addr;
    logic [63:0] mem_rd_data, mem_wr_data;
    logic        mem_wr_req, mem_wr_last, mem_wr_ack;

    int checks = 0, errors = 0;
    int rd_count = 0, wr_beats = 0, blocks = 0, irq_cnt = 0, hold_err = 0;

    logic [63:0] dmem [256];
    logic [63:0] rmem [256];

    always #2 clk = ~clk;

    desc_cpl_dma uut (.*);

    // List table: descriptor word per row, {addr | valid<<2 | chan}.
    localparam logic [63:0] TBL [8] = '{
        64'h1000 | 64'h4 | 64'd0,
        64'h2008 | 64'h4 | 64'd1,
        64'h3000 | 64'h4 | 64'd3,
        64'h4010 | 64'h4 | 64'd2,
        64'h5018 | 64'h4 | 64'd0,
        64'h6020 | 64'h4 | 64'd2,
        64'h7000 | 64'h0 | 64'd1,
        64'h8000 | 64'h4 | 64'd0
    };

    // Memory model: one-cycle read/write handshakes and write capture.
    logic        p_req = 1'b0, p_ack = 1'b0;
    logic [31:0] p_addr = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_valid <= 1'b0;
            mem_wr_ack   <= 1'b0;
            mem_rd_data  <= '0;
            p_req <= 1'b0; p_ack <= 1'b0;
        end else begin
            mem_rd_valid <= mem_rd_req && !mem_rd_valid;
            mem_rd_data  <= dmem[mem_rd_addr[10:3]];
            if (mem_rd_req && mem_rd_valid) rd_count <= rd_count + 1;
            mem_wr_ack <= mem_wr_req && !mem_wr_ack;
            if (mem_wr_req && mem_wr_ack) begin
                rmem[mem_wr_addr[10:3]] <= mem_wr_data;
                wr_beats <= wr_beats + 1;
                if (mem_wr_last) blocks <= blocks + 1;
            end
            if (irq) irq_cnt <= irq_cnt + 1;
            if (p_req && !p_ack && (!mem_wr_req || mem_wr_addr != p_addr))
                hold_err <= hold_err + 1;
            p_req <= mem_wr_req; p_ack <= mem_wr_ack; p_addr <= mem_wr_addr;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pop_chk(input int ch, input logic [31:0] exp, input string tag);
        int n = 0;
        @(negedge clk);
        while (!req_valid[ch] && n < 200) begin @(negedge clk); n++; end
        chk(tag, req_addr[ch*32 +: 32], exp);
        req_pop[ch] = 1'b1;
        @(negedge clk);
        req_pop[ch] = 1'b0;
    endtask

    task automatic push_cpl(input logic [1:0] ch, input logic [19:0] len, input logic [7:0] st);
        @(negedge clk);
        while (!cpl_ready) @(negedge clk);
        cpl_valid = 1'b1; cpl_chan = ch; cpl_len = len; cpl_status = st;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic ring_door(input logic [31:0] base);
        @(negedge clk);
        desc_base = base; doorbell = 1'b1;
        @(negedge clk);
        doorbell = 1'b0;
    endtask

    function automatic logic [63:0] rec(input logic [1:0] ch, input logic [19:0] len, input logic [7:0] st);
        return {30'd0, ch, 4'd0, st, len};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base_rd, base_irq;
        for (int i = 0; i < 256; i++) begin dmem[i] = '0; rmem[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        chk("R12 rd_req", mem_rd_req, 0);
        chk("R12 wr_req", mem_wr_req, 0);
        chk("R12 req_valid", req_valid, 0);
        chk("R12 wr_idx", ring_wr_idx, 0);
        chk("R12 irq", irq, 0);
        chk("R12 cpl_ready", cpl_ready, 1);
        rst_n = 1'b1;

        // R1 R2 R3: table-driven list walk
        for (int i = 0; i < 8; i++) dmem[i] = TBL[i];
        ring_door(32'h0);
        repeat (80) @(negedge clk);
        chk("R2 reads stop at end entry", rd_count, 7);
        for (int ch = 0; ch < 3; ch++) begin
            for (int i = 0; i < 8; i++) begin
                if (!TBL[i][2]) break;
                if (int'(TBL[i][1:0]) == ch)
                    pop_chk(ch, {TBL[i][31:3], 3'b000}, "R1 R3 page addr");
            end
        end
        @(negedge clk);
        chk("R2 R3 nothing extra queued", req_valid, 0);

        // R4: queue full stalls parsing, nothing dropped
        for (int k = 0; k < 6; k++) dmem[16+k] = 64'((k + 1) * 32'h100) | 64'h4;
        dmem[22] = '0;
        base_rd = rd_count;
        ring_door(32'h80);
        repeat (80) @(negedge clk);
        chk("R4 parse stalled on full queue", rd_count - base_rd, 5);
        for (int k = 0; k < 6; k++) begin
            pop_chk(0, 32'((k + 1) * 32'h100), "R4 order kept");
            repeat (5) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        chk("R4 list completed", rd_count - base_rd, 7);
        chk("R4 queue drained", req_valid, 0);

        // R5 R6 R8 R10: threshold-triggered block
        push_cpl(2'd0, 20'd100, 8'h11);
        push_cpl(2'd2, 20'd200, 8'h22);
        repeat (50) @(negedge clk);
        chk("R6 below threshold no write", blocks, 0);
        push_cpl(2'd1, 20'd300, 8'h33);
        repeat (30) @(negedge clk);
        chk("R6 beats", wr_beats, 3);
        chk("R6 one block", blocks, 1);
        chk("R5 rec0", rmem[128], rec(2'd0, 20'd100, 8'h11));
        chk("R5 rec1", rmem[129], rec(2'd2, 20'd200, 8'h22));
        chk("R5 rec2", rmem[130], rec(2'd1, 20'd300, 8'h33));
        chk("R8 wr_idx", ring_wr_idx, 3);
        chk("R10 irq pulse", irq_cnt, 1);

        // R7: timeout flush
        cpl_threshold = 4'd8; cpl_timeout = 16'd40;
        push_cpl(2'd2, 20'hFFFFF, 8'hFF);
        repeat (20) @(negedge clk);
        chk("R7 not early", blocks, 1);
        repeat (60) @(negedge clk);
        chk("R7 flushed", blocks, 2);
        chk("R7 rec", rmem[131], rec(2'd2, 20'hFFFFF, 8'hFF));
        chk("R8 wr_idx after flush", ring_wr_idx, 4);

        // R9: ring full stall, then wrap
        cpl_threshold = 4'd5; cpl_timeout = 16'd0;
        for (int k = 0; k < 5; k++) push_cpl(2'(k % 3), 20'(k + 10), 8'(k + 1));
        repeat (40) @(negedge clk);
        chk("R9 block cut to free space", ring_wr_idx, 7);
        chk("R9 beats", wr_beats, 7);
        cpl_threshold = 4'd1;
        repeat (50) @(negedge clk);
        chk("R9 stalled while full", ring_wr_idx, 7);
        chk("R9 no beats while full", wr_beats, 7);
        ring_rd_idx = 4'd5;
        repeat (40) @(negedge clk);
        chk("R6 wrapped index", ring_wr_idx, 1);
        chk("R6 last slot", rmem[135], rec(2'd0, 20'd13, 8'd4));
        chk("R6 slot zero", rmem[128], rec(2'd1, 20'd14, 8'd5));

        // R10: interrupt disabled
        irq_en = 1'b0;
        base_irq = irq_cnt;
        push_cpl(2'd1, 20'd7, 8'h01);
        repeat (30) @(negedge clk);
        chk("R8 wr_idx advance", ring_wr_idx, 2);
        chk("R10 no irq when off", irq_cnt, base_irq);
        chk("R11 write hold", hold_err, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule